// File: doc/BRIEF.md
# Single-Line Remote-Write Watch

This block sits beside a cache controller and watches one memory line for writes made by other agents. Software arms it by loading a line address into a watch register, installing a handler address, and enabling alerts. From then on every accepted snooped coherence transaction is compared against the stored line tag. When a remote agent writes any byte of that line, the block raises an alert request toward the core and presents the handler address the core should branch to.

The comparison uses only the stored tag, never the local cache state. A capacity or conflict eviction of the line from the local cache therefore does not raise an alert and does not end the watch. The only cause of an alert is a remote write, so the block has no register that reports a cause. Releasing the watch can also clear the handler in the same command; a parameter selects this merged behaviour.

Snooped transactions arrive on a valid/ready stream. A transaction is accepted on a cycle where both `snoop_valid` and `snoop_ready` are high. `snoop_ready` drops while an alert is waiting for the core, so no snoop is lost or reordered behind an undelivered alert. The alert is also a valid/ready pair: `alert_valid` stays high, with `alert_handler` on the bus, until the core raises `alert_ready`.

Top module: `line_watch_unit`

## Requirements
- R1: After reset `alert_valid` is 0, `snoop_ready` is 1, `alert_handler` is 0, alerts are disabled and no line is watched.
- R2: An accepted snoop with `snoop_remote`=1 and `snoop_write`=1 whose address matches the watched line sets `alert_valid` on the next cycle. This requires a watched line, alerts enabled and a handler installed. Address bits [5:0] are a byte offset and are ignored in the match.
- R3: A remote write whose address differs from the watched line in any bit at position 6 or above does not raise an alert.
- R4: Remote reads (`snoop_write`=0) and local transactions (`snoop_remote`=0) never raise an alert, even when they hit the watched line.
- R5: `cmd_release` clears the watch. Remote writes seen while no line is watched are ignored.
- R6: With the merged-release parameter set (default 1), `cmd_release` also clears the handler, so `alert_handler` reads 0. No alert is raised until a handler is installed again.
- R7: While `alert_valid` is high and `alert_ready` is low, `alert_valid` stays high and `snoop_ready` is low. Snoops offered in that time are not accepted.
- R8: Raising an alert disables alerts and drops the watch. A later matching remote write alerts again only after both a new `cmd_watch` and a `cmd_reenable`.
- R9: When `cmd_watch` and `cmd_release` arrive in the same cycle, the release wins and no line is watched.
- R10: `alert_handler` shows the address given by the most recent `cmd_set_handler`. A set in the same cycle as a release takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_watch | input | 1 | Load a line address into the watch register |
| cmd_watch_addr | input | ADDR_W | Byte address inside the line to watch |
| cmd_release | input | 1 | Stop watching (and clear handler when merged) |
| cmd_set_handler | input | 1 | Install a handler address |
| cmd_handler_addr | input | HANDLER_W | Handler address to install |
| cmd_reenable | input | 1 | Set the alert enable flag |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_ready | output | 1 | Block accepts the snooped transaction |
| snoop_addr | input | ADDR_W | Byte address of the snooped transaction |
| snoop_write | input | 1 | 1 for a write, 0 for a read |
| snoop_remote | input | 1 | 1 when another agent issued the transaction |
| alert_valid | output | 1 | Alert request to the core |
| alert_ready | input | 1 | Core takes the alert |
| alert_handler | output | HANDLER_W | Installed handler address |

## Verification
The hardest situation to reach is the re-arm window after an alert. A matching write must be ignored while only one of the two re-arm steps has been done, and must alert once both are done. The stimulus takes an alert, repeats the matching write, then re-enables alone, then reloads the watch, with a write after each step. A cycle-accurate reference model is compared on every clock. The stimulus also holds `alert_ready` low for several cycles while snoops are offered, to show that back-pressure does not lose the pending alert.

// File: rtl/line_watch_pkg.sv
package line_watch_pkg;
  typedef enum logic [0:0] {
    ALERT_IDLE = 1'b0,
    ALERT_PEND = 1'b1
  } alert_state_e;

  typedef struct packed {
    logic remote;
    logic write;
  } snoop_kind_t;
endpackage

// File: rtl/watch_tag_reg.sv
module watch_tag_reg #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              release_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              valid_o,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tag_q;
  logic             valid_q;

  // R5 R9: release outranks load; a load outranks the kill from a detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (release_i) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tag_q   <= load_addr_i[ADDR_W-1:OFS_W];
    end else if (kill_i) begin
      valid_q <= 1'b0;
    end
  end

  // R2 R3: offset bits take no part in the compare
  assign hit_o   = valid_q && (probe_addr_i[ADDR_W-1:OFS_W] == tag_q);
  assign valid_o = valid_q;
endmodule

// File: rtl/handler_reg.sv
module handler_reg #(
  parameter int HANDLER_W        = 32,
  parameter bit CLEAR_ON_RELEASE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_i,
  input  logic [HANDLER_W-1:0] set_addr_i,
  input  logic                 release_i,
  output logic [HANDLER_W-1:0] handler_o,
  output logic                 installed_o
);
  logic [HANDLER_W-1:0] addr_q;
  logic                 inst_q;
  logic                 clr;

  generate
    if (CLEAR_ON_RELEASE) begin : g_merged
      assign clr = release_i;
    end else begin : g_split
      assign clr = 1'b0;
    end
  endgenerate

  // R6 R10: a set in the same cycle as a release wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inst_q <= 1'b0;
    end else if (set_i) begin
      addr_q <= set_addr_i;
      inst_q <= 1'b1;
    end else if (clr) begin
      addr_q <= '0;
      inst_q <= 1'b0;
    end
  end

  assign handler_o   = addr_q;
  assign installed_o = inst_q;
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import line_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reenable_i,
  input  logic detect_i,
  input  logic take_i,
  output logic enable_o,
  output logic alert_o
);
  alert_state_e state_q;
  logic         en_q;

  // R8: a detection clears the enable even if a re-enable arrives with it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (detect_i) begin
      en_q <= 1'b0;
    end else if (reenable_i) begin
      en_q <= 1'b1;
    end
  end

  // R7: alert held until the core takes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ALERT_IDLE;
    end else begin
      unique case (state_q)
        ALERT_IDLE: if (detect_i) state_q <= ALERT_PEND;
        ALERT_PEND: if (take_i)   state_q <= ALERT_IDLE;
        default:                  state_q <= ALERT_IDLE;
      endcase
    end
  end

  assign enable_o = en_q;
  assign alert_o  = (state_q == ALERT_PEND);
endmodule

// File: rtl/line_watch_unit.sv
module line_watch_unit
  import line_watch_pkg::*;
#(
  parameter int ADDR_W                 = 32,
  parameter int LINE_BYTES             = 64,
  parameter int HANDLER_W              = 32,
  parameter bit RELEASE_CLEARS_HANDLER = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_watch,
  input  logic [ADDR_W-1:0]    cmd_watch_addr,
  input  logic                 cmd_release,
  input  logic                 cmd_set_handler,
  input  logic [HANDLER_W-1:0] cmd_handler_addr,
  input  logic                 cmd_reenable,
  input  logic                 snoop_valid,
  output logic                 snoop_ready,
  input  logic [ADDR_W-1:0]    snoop_addr,
  input  logic                 snoop_write,
  input  logic                 snoop_remote,
  output logic                 alert_valid,
  input  logic                 alert_ready,
  output logic [HANDLER_W-1:0] alert_handler
);
  localparam int OFS_W = $clog2(LINE_BYTES);

  snoop_kind_t kind;
  logic        snoop_fire;
  logic        watch_valid;
  logic        watch_hit;
  logic        handler_installed;
  logic        alert_enable;
  logic        detect;

  assign kind.remote = snoop_remote;
  assign kind.write  = snoop_write;

  // R7: back-pressure snoops while an alert waits for the core
  assign snoop_ready = !alert_valid;
  assign snoop_fire  = snoop_valid && snoop_ready;

  // R2 R4: only remote writes that hit an armed watch count
  assign detect = snoop_fire && kind.remote && kind.write && watch_hit
                  && alert_enable && handler_installed;

  watch_tag_reg #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_watch (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (cmd_watch),
    .load_addr_i  (cmd_watch_addr),
    .release_i    (cmd_release),
    .kill_i       (detect),
    .probe_addr_i (snoop_addr),
    .valid_o      (watch_valid),
    .hit_o        (watch_hit)
  );

  handler_reg #(
    .HANDLER_W        (HANDLER_W),
    .CLEAR_ON_RELEASE (RELEASE_CLEARS_HANDLER)
  ) u_handler (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (cmd_set_handler),
    .set_addr_i  (cmd_handler_addr),
    .release_i   (cmd_release),
    .handler_o   (alert_handler),
    .installed_o (handler_installed)
  );

  alert_ctrl u_alert (
    .clk        (clk),
    .rst_n      (rst_n),
    .reenable_i (cmd_reenable),
    .detect_i   (detect),
    .take_i     (alert_ready),
    .enable_o   (alert_enable),
    .alert_o    (alert_valid)
  );
endmodule

// File: rtl/line_watch_checker.sv
module line_watch_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_release,
  input logic snoop_valid,
  input logic snoop_ready,
  input logic snoop_write,
  input logic snoop_remote,
  input logic alert_valid,
  input logic alert_ready,
  input logic watch_valid
);
  assert_rise_needs_remote_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_valid) |-> $past(snoop_valid && snoop_remote && snoop_write));

  assert_no_alert_from_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && (!snoop_remote || !snoop_write)) |=> !$rose(alert_valid));

  assert_release_drops_watch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_release |=> !watch_valid);

  assert_alert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_valid && !alert_ready) |=> alert_valid);

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_valid |-> !snoop_ready);

  assert_single_alert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_valid && alert_ready) |=> !alert_valid);
endmodule

bind line_watch_unit line_watch_checker u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_release  (cmd_release),
  .snoop_valid  (snoop_valid),
  .snoop_ready  (snoop_ready),
  .snoop_write  (snoop_write),
  .snoop_remote (snoop_remote),
  .alert_valid  (alert_valid),
  .alert_ready  (alert_ready),
  .watch_valid  (watch_valid)
);

// File: tb/line_watch_unit_tb.sv
module line_watch_unit_tb;
  localparam int AW = 32;
  localparam int HW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_watch = 0, cmd_release = 0, cmd_set_handler = 0, cmd_reenable = 0;
  logic [AW-1:0] cmd_watch_addr = '0;
  logic [HW-1:0] cmd_handler_addr = '0;
  logic          snoop_valid = 0, snoop_write = 0, snoop_remote = 0, alert_ready = 0;
  logic [AW-1:0] snoop_addr = '0;
  logic          snoop_ready, alert_valid;
  logic [HW-1:0] alert_handler;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_watch_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_watch(cmd_watch), .cmd_watch_addr(cmd_watch_addr),
    .cmd_release(cmd_release), .cmd_set_handler(cmd_set_handler),
    .cmd_handler_addr(cmd_handler_addr), .cmd_reenable(cmd_reenable),
    .snoop_valid(snoop_valid), .snoop_ready(snoop_ready), .snoop_addr(snoop_addr),
    .snoop_write(snoop_write), .snoop_remote(snoop_remote),
    .alert_valid(alert_valid), .alert_ready(alert_ready), .alert_handler(alert_handler)
  );

  // Behavioural reference model
  bit          m_wv, m_hv, m_en, m_al;
  int unsigned m_line;
  logic [HW-1:0] m_h;
  bit          m_det;

  always_comb
    m_det = snoop_valid && !m_al && snoop_remote && snoop_write && m_wv &&
            ((snoop_addr / 64) == m_line) && m_en && m_hv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wv <= 0; m_hv <= 0; m_en <= 0; m_al <= 0; m_line <= 0; m_h <= '0;
    end else begin
      if (cmd_release) m_wv <= 0;
      else if (cmd_watch) begin m_wv <= 1; m_line <= cmd_watch_addr / 64; end
      else if (m_det) m_wv <= 0;
      if (cmd_set_handler) begin m_hv <= 1; m_h <= cmd_handler_addr; end
      else if (cmd_release) begin m_hv <= 0; m_h <= '0; end
      if (m_det) m_en <= 0;
      else if (cmd_reenable) m_en <= 1;
      if (m_det) m_al <= 1;
      else if (m_al && alert_ready) m_al <= 0;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One clock: inputs set by caller before, compare at the following negedge
  task automatic cyc();
    @(negedge clk);
    chk(alert_valid === m_al, "model alert_valid R2 R7", alert_valid, m_al);
    chk(snoop_ready === !m_al, "model snoop_ready R7", snoop_ready, !m_al);
    chk(alert_handler === m_h, "model alert_handler R10", alert_handler, m_h);
  endtask

  task automatic idle();
    cmd_watch = 0; cmd_release = 0; cmd_set_handler = 0; cmd_reenable = 0;
    snoop_valid = 0; snoop_write = 0; snoop_remote = 0; alert_ready = 0;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input bit remote, input bit wr);
    idle();
    snoop_valid = 1; snoop_addr = a; snoop_remote = remote; snoop_write = wr;
    cyc();
    idle();
  endtask

  task automatic take();
    idle(); alert_ready = 1; cyc(); idle();
  endtask

  localparam logic [AW-1:0] LINE_A = 32'h0000_1240;

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(alert_valid === 0 && snoop_ready === 1 && alert_handler === 0, "R1 reset outputs",
        {alert_valid, snoop_ready}, 2'b01);
    rst_n = 1;
    cyc();

    // arm
    cmd_set_handler = 1; cmd_handler_addr = 32'hCAFE_0100;
    cmd_watch = 1; cmd_watch_addr = LINE_A + 5; cmd_reenable = 1;
    cyc(); idle();
    chk(alert_handler === 32'hCAFE_0100, "R10 handler visible", alert_handler, 32'hCAFE_0100);

    snoop(LINE_A, 1, 0);
    chk(alert_valid === 0, "R4 remote read ignored", alert_valid, 0);
    snoop(LINE_A + 8, 0, 1);
    chk(alert_valid === 0, "R4 local write ignored", alert_valid, 0);
    snoop(LINE_A + 64, 1, 1);
    chk(alert_valid === 0, "R3 next line ignored", alert_valid, 0);
    snoop(LINE_A ^ 32'h8000_0000, 1, 1);
    chk(alert_valid === 0, "R3 high bit differs ignored", alert_valid, 0);

    snoop(LINE_A + 6'h2B, 1, 1);
    chk(alert_valid === 1, "R2 write at offset alerts", alert_valid, 1);
    // R7: hold, offer snoops under back-pressure
    idle(); snoop_valid = 1; snoop_addr = LINE_A; snoop_remote = 1; snoop_write = 1;
    cyc(); cyc();
    chk(alert_valid === 1 && snoop_ready === 0, "R7 held with back-pressure",
        {alert_valid, snoop_ready}, 2'b10);
    take();
    chk(alert_valid === 0, "R7 alert taken", alert_valid, 0);

    // R8: re-arm needs both steps
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R8 no second alert", alert_valid, 0);
    idle(); cmd_reenable = 1; cyc(); idle();
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R8 reenable alone", alert_valid, 0);
    idle(); cmd_watch = 1; cmd_watch_addr = LINE_A; cyc(); idle();
    snoop(LINE_A + 63, 1, 1);
    chk(alert_valid === 1, "R8 rearmed alerts", alert_valid, 1);
    take();

    // R8: reload alone after an alert
    idle(); cmd_watch = 1; cmd_watch_addr = LINE_A; cyc(); idle();
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R8 reload alone", alert_valid, 0);

    // R5 R6: release clears watch and handler
    idle(); cmd_reenable = 1; cyc(); idle();
    idle(); cmd_release = 1; cyc(); idle();
    chk(alert_handler === 0, "R6 handler cleared by release", alert_handler, 0);
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R5 released line ignored", alert_valid, 0);
    idle(); cmd_watch = 1; cmd_watch_addr = LINE_A; cyc(); idle();
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R6 no handler no alert", alert_valid, 0);

    // R10: set with release in same cycle, set wins
    idle(); cmd_set_handler = 1; cmd_handler_addr = 32'h0000_BEE0; cmd_release = 1; cyc(); idle();
    chk(alert_handler === 32'h0000_BEE0, "R10 set beats release", alert_handler, 32'h0000_BEE0);
    idle(); cmd_watch = 1; cmd_watch_addr = LINE_A + 64; cyc(); idle();
    snoop(LINE_A + 64 + 1, 1, 1);
    chk(alert_valid === 1, "R10 alert after new handler", alert_valid, 1);
    chk(alert_handler === 32'h0000_BEE0, "R10 alert handler value", alert_handler, 32'h0000_BEE0);
    take();

    // R9: watch and release together
    idle(); cmd_reenable = 1; cyc(); idle();
    idle(); cmd_watch = 1; cmd_watch_addr = LINE_A; cmd_release = 1; cyc(); idle();
    idle(); cmd_set_handler = 1; cmd_handler_addr = 32'h11; cyc(); idle();
    snoop(LINE_A, 1, 1);
    chk(alert_valid === 0, "R9 release wins over watch", alert_valid, 0);

    repeat (3) cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule